// File: doc/BRIEF.md
# Serial Frame Transmitter

This block turns characters from a transmit holding stage into asynchronous serial frames on a single output line. A 16x oversampling baud tick sets the pace, and each bit is held for a fixed number of ticks. A frame is a low start bit, then 5 to 8 data bits sent least-significant first, then an optional parity bit, then one or two high stop bits. Between frames the line rests high.

Static line-control inputs set the frame format: the word-length code, parity on or off, even or odd parity, stick parity and two stop bits. A break request drives the line low, but only after the character in progress has ended. A frame starts only on a baud tick, and only when the holding stage offers data, transmit is enabled and, if flow gating is on, clear-to-send is asserted. In the cycle a frame starts, the block pulses `q_pop` to take the character. The busy flag reports pending or in-flight work.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset with no data offered, `txd` is 1, `busy` is 0 and `q_pop` is 0.
- R2: A frame starts only in a cycle with `baud_tick` high. `q_pop` is high in that cycle. From the next cycle `txd` carries, in order: start bit 0, the data bits least-significant first, the parity bit when `par_en`=1, then the stop bits (1).
- R3: The `wlen` code values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected length are not sent.
- R4: Every bit of the frame lasts exactly 16 baud ticks.
- R5: With `par_stick`=0, `par_even`=1 makes the number of ones across the data and parity bits even, and `par_even`=0 makes it odd.
- R6: With `par_en`=1 and `par_stick`=1, the parity bit is the inverse of `par_even`, whatever the data.
- R7: `two_stop`=1 sends two stop bits, and `two_stop`=0 sends one. After the last stop bit, the line returns to idle.
- R8: Raising `send_break` during a frame does not change that frame. Once the frame ends, `txd` is held at 0 and no frame starts. When `send_break` falls, the line returns to 1.
- R9: `busy` is 1 whenever `q_valid` is 1, even with `tx_en`=0, and throughout every frame until its last stop bit is done.
- R10: With `tx_en`=0, no frame starts. Dropping `tx_en` during a frame still lets that frame finish unchanged.
- R11: With `cts_en`=1, a frame starts only while `cts`=1. Dropping `cts` during a frame does not shorten it. With `cts_en`=0, `cts` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en | input | 1 | Permits new frames to start |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear-to-send, active high |
| q_valid | input | 1 | Holding stage has a character |
| q_data | input | 8 | Character offered by the holding stage |
| q_pop | output | 1 | Character taken this cycle |
| wlen | input | 2 | Word length code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| two_stop | input | 1 | Two stop bits |
| send_break | input | 1 | Hold line low after the current frame |
| txd | output | 1 | Serial output |
| busy | output | 1 | Character pending or frame in flight |

## Verification
`q_pop` is combinational, so it is valid in the same cycle as the tick that starts the frame. The start bit appears on `txd` one clock later. Every following bit changes on the clock edge that consumes the sixteenth tick of the previous bit. The bench counts consumed ticks itself and samples `txd` and `busy` on the falling edge after every clock of a frame. At that moment the expected bit index is the tick count divided by 16, so each check lands between the registered change and the next edge. `busy` is checked at the same sampling points: it must follow `q_valid` with no delay.

// File: rtl/uft_pkg.sv
// Shared constants and the line-format bundle for the serial frame transmitter.
// Assumes characters of at most 8 bits and at most one parity and two stop bits.
package uft_pkg;
    localparam int DATA_MAX = 8;
    localparam int FRAME_W  = DATA_MAX + 4;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       two_stop;
    } uft_fmt_t;
endpackage

// File: rtl/uft_framer.sv
// Builds the full frame (LSB = start bit) and its length in bits from one
// character and the line format. Unused high positions are filled with 1s.
// Assumes the format is stable while a frame is loaded.
module uft_framer
    import uft_pkg::*;
(
    input  logic [DATA_MAX-1:0] data,
    input  uft_fmt_t            fmt,
    output logic [FRAME_W-1:0]  frame,
    output logic [LEN_W-1:0]    len
);
    logic [DATA_MAX-1:0] mask;
    logic [3:0]          nbits;
    logic [3:0]          ppos;
    logic                dpar;
    logic                pbit;
    logic [FRAME_W-1:0]  base;
    logic [FRAME_W-1:0]  pmask;

    // Data mask, parity value and parity position from the format.
    always_comb begin
        mask  = {DATA_MAX{1'b1}} >> (2'd3 - fmt.wlen);
        nbits = 4'd5 + {2'b00, fmt.wlen};
        ppos  = nbits + 4'd1;
        dpar  = ^(data & mask);
        if (fmt.par_stick) pbit = ~fmt.par_even;
        else               pbit = fmt.par_even ? dpar : ~dpar;
    end

    // Frame assembly: start bit, masked data, optional parity, stop ones.
    always_comb begin
        base  = {3'b111, data | ~mask, 1'b0};
        pmask = FRAME_W'(1) << ppos;
        if (fmt.par_en) frame = (base & ~pmask) | (pbit ? pmask : '0);
        else            frame = base;
        len = LEN_W'(nbits) + LEN_W'(2) + LEN_W'(fmt.par_en) + LEN_W'(fmt.two_stop);
    end
endmodule

// File: rtl/uft_bit_timer.sv
// Counts baud ticks within one bit and flags the tick that ends the bit.
// Assumes TICKS >= 2; the counter is held at zero while no frame runs.
module uft_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = $clog2(TICKS);
    logic [CW-1:0] cnt;

    assign bit_end = run && tick && (cnt == CW'(TICKS - 1));

    // Tick counter that wraps at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (bit_end) cnt <= '0;
        else if (tick)    cnt <= cnt + CW'(1);
    end

    // R4: after a bit ends, the count restarts from zero.
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (cnt == '0));
endmodule

// File: rtl/uft_shifter.sv
// Holds the loaded frame, shifts it one bit per bit period and tracks how many
// bits remain. Assumes load is only raised while no frame is active.
module uft_shifter
    import uft_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   len,
    input  logic               bit_end,
    output logic               active,
    output logic               line_bit
);
    logic [FRAME_W-1:0] sr;
    logic [LEN_W-1:0]   left;

    assign active   = (left != '0);
    assign line_bit = sr[0];

    // Frame register and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '1;
            left <= '0;
        end else if (load) begin
            sr   <= frame;
            left <= len;
        end else if (bit_end && active) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - LEN_W'(1);
        end
    end

    // R7: a loaded frame is between 7 and FRAME_W bits long.
    a_r7_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len >= LEN_W'(7) && len <= LEN_W'(FRAME_W)));

    // R4: the line bit holds while a bit period is in progress.
    a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_end) |=> $stable(line_bit));
endmodule

// File: rtl/uart_frame_tx.sv
// Serial frame transmitter top: decides when a frame may start, takes the
// character from the holding stage and drives the line. Assumes baud_tick is
// a one-cycle pulse at TICKS times the bit rate and line-control inputs only
// change between frames (send_break may change at any time).
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                tx_en,
    input  logic                cts_en,
    input  logic                cts,
    input  logic                q_valid,
    input  logic [DATA_MAX-1:0] q_data,
    output logic                q_pop,
    input  logic [1:0]          wlen,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    input  logic                two_stop,
    input  logic                send_break,
    output logic                txd,
    output logic                busy
);
    uft_fmt_t           fmt;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   len;
    logic               active;
    logic               line_bit;
    logic               bit_end;
    logic               flow_ok;

    // Format bundle from the line-control pins.
    always_comb begin
        fmt.wlen      = wlen;
        fmt.par_en    = par_en;
        fmt.par_even  = par_even;
        fmt.par_stick = par_stick;
        fmt.two_stop  = two_stop;
    end

    // Start decision and line drive.
    always_comb begin
        flow_ok = !cts_en || cts;
        q_pop   = !active && baud_tick && q_valid && tx_en && flow_ok && !send_break;
        txd     = active ? line_bit : ~send_break;
        busy    = q_valid || active;
    end

    uft_framer u_framer (
        .data  (q_data),
        .fmt   (fmt),
        .frame (frame),
        .len   (len)
    );

    uft_bit_timer #(.TICKS(TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    uft_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q_pop),
        .frame    (frame),
        .len      (len),
        .bit_end  (bit_end),
        .active   (active),
        .line_bit (line_bit)
    );

    // R2: the cycle after a character is taken, the start bit is on the line.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> !txd);

    // R7: the last bit of every frame is a stop bit.
    a_r7_stop_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(txd));
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       tx_en = 1'b0, cts_en = 1'b0, cts = 1'b0;
    logic       q_valid = 1'b0;
    logic [7:0] q_data = 8'h00;
    logic       q_pop;
    logic [1:0] wlen = 2'd3;
    logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, two_stop = 1'b0;
    logic       send_break = 1'b0;
    logic       txd, busy;
    logic       tdiv = 1'b0;
    int         checks = 0, errs = 0, cyc = 0;

    always #5 clk = ~clk;

    // Baud tick every second clock.
    always @(posedge clk) tdiv <= ~tdiv;
    assign baud_tick = (tdiv == 1'b0);

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .cts_en(cts_en), .cts(cts), .q_valid(q_valid), .q_data(q_data),
        .q_pop(q_pop), .wlen(wlen), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .two_stop(two_stop), .send_break(send_break),
        .txd(txd), .busy(busy)
    );

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk("watchdog", 1'b0, cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    // Expected line bit at frame position idx.
    function automatic bit exp_bit(input logic [7:0] d, input int idx, input int nb,
                                   input bit pe, input bit pv);
        if (idx == 0) return 1'b0;
        if (idx <= nb) return d[idx-1];
        if (pe && idx == nb + 1) return pv;
        return 1'b1;
    endfunction

    // Sends one character and checks every sampled cycle of its frame.
    // kind: 1 drop tx_en, 2 raise send_break, 3 drop cts, at tick count chg_at.
    task automatic run_frame(input string req, input logic [7:0] d,
                             input int chg_at, input int kind);
        int nb = 5 + int'(wlen);
        int ones = 0;
        int nbits;
        int k = 0;
        int bad = 0, bad_k = -1, bad_a = 0, bad_e = 0;
        bit pv;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        if (par_stick) pv = ~par_even;
        else if (par_even) pv = bit'(ones % 2);
        else pv = bit'(1 - ones % 2);
        nbits = 2 + nb + int'(par_en) + int'(two_stop);
        q_data = d;
        q_valid = 1'b1;
        do @(negedge clk); while (!q_pop);
        @(posedge clk);
        #1 q_valid = 1'b0;
        while (k < 16 * nbits) begin
            bit e;
            @(negedge clk);
            if (k == chg_at) begin
                if (kind == 1) tx_en = 1'b0;
                if (kind == 2) send_break = 1'b1;
                if (kind == 3) cts = 1'b0;
            end
            e = exp_bit(d, k / 16, nb, par_en, pv);
            if (txd !== e || busy !== 1'b1) begin
                bad++;
                if (bad_k < 0) begin bad_k = k; bad_a = int'(txd); bad_e = int'(e); end
            end
            if (baud_tick) k++;
        end
        if (bad != 0) $display("  first mismatch at tick %0d data=%0h wlen=%0d", bad_k, d, wlen);
        chk({req, " frame bits"}, bad == 0, bad_a, bad_e);
        @(negedge clk);
        chk("R7 R8 line level after frame", txd === ~send_break, int'(txd), int'(~send_break));
        chk("R9 busy clears after frame", busy === 1'b0, int'(busy), 0);
    endtask

    // Observes n cycles with no frame start and a fixed line level.
    task automatic hold_check(input string req, input int n, input bit etxd, input bit ebusy);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (q_pop !== 1'b0 || txd !== etxd || busy !== ebusy) bad++;
        end
        chk(req, bad == 0, bad, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle txd", txd === 1'b1, int'(txd), 1);
        chk("R1 idle busy", busy === 1'b0, int'(busy), 0);
        chk("R1 idle pop", q_pop === 1'b0, int'(q_pop), 0);
        tx_en = 1'b1;

        // Sweep word length, parity mode and stop count.
        for (int w = 0; w < 4; w++)
            for (int pm = 0; pm < 5; pm++)
                for (int ts = 0; ts < 2; ts++)
                    for (int j = 0; j < 2; j++) begin
                        logic [7:0] d;
                        string tag;
                        wlen = 2'(w);
                        par_en = (pm != 0);
                        par_even = (pm == 2 || pm == 4);
                        par_stick = (pm >= 3);
                        two_stop = ts[0];
                        d = 8'((w * 37 + pm * 11 + ts * 5 + j * 91) ^ (j ? 8'hE0 : 8'h1B));
                        tag = (pm >= 3) ? "R2 R3 R4 R6 R7" : "R2 R3 R4 R5 R7";
                        run_frame(tag, d, -1, 0);
                    end

        // R9 and R10: disabled transmitter with data pending.
        wlen = 2'd3; par_en = 1'b0; par_stick = 1'b0; two_stop = 1'b0;
        tx_en = 1'b0;
        q_data = 8'h55;
        q_valid = 1'b1;
        hold_check("R9 R10 pending while disabled", 60, 1'b1, 1'b1);
        tx_en = 1'b1;
        run_frame("R10 disable mid-frame", 8'h55, 40, 1);
        q_valid = 1'b1;
        hold_check("R10 no start after disable", 80, 1'b1, 1'b1);
        q_valid = 1'b0;
        tx_en = 1'b1;

        // R8: break raised mid-frame.
        run_frame("R8 break mid-frame", 8'h0F, 30, 2);
        q_valid = 1'b1;
        hold_check("R8 break holds line low", 80, 1'b0, 1'b1);
        q_valid = 1'b0;
        send_break = 1'b0;
        @(negedge clk);
        chk("R8 line high after break", txd === 1'b1, int'(txd), 1);

        // R11: clear-to-send gating.
        cts_en = 1'b1; cts = 1'b0;
        q_valid = 1'b1;
        hold_check("R11 gated by cts", 80, 1'b1, 1'b1);
        cts = 1'b1;
        run_frame("R11 cts drop mid-frame", 8'h81, 50, 3);
        q_valid = 1'b1;
        hold_check("R11 no start without cts", 60, 1'b1, 1'b1);
        cts_en = 1'b0;
        run_frame("R11 cts ignored when gating off", 8'h42, -1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule